// File: doc/BRIEF.md
# Boundary Scan Data Register Chain

This block is the boundary scan data register for a group of bidirectional I/O pads. Each pad owns three serial shift cells and three parallel update latches, one set each for the input value, the output value and the output enable. Two fixed non-pin cells sit at the serial-out end of the chain and one sits at the serial-in end. The serial path runs from `tdi` through every cell to `tdo`.

A test access port controller drives the capture, shift and update strobes and the external-test mode flag. When the mode flag is set, the update latches take control of the pads, and the core sees the latched input values. When the flag is clear, the pads and the core are connected straight through and the chain only observes them. Capture, shift and update all happen on the rising edge of the test clock `clk`.

Top module: `bsr_chain`

## Requirements
- R1: The chain holds 3*NUM_PADS+3 bits. A pattern of that many bits shifted in at `tdi` comes out at `tdo` in the same order, starting immediately after its last bit has been shifted in.
- R2: The chain order is fixed. Bit 0 is the TDO-enable cell and bit 1 is the TDO-data cell. For pad p, bit 2+3p is the input cell, bit 3+3p is the output cell and bit 4+3p is the enable cell. The last bit, 3*NUM_PADS+2, is the update-control cell.
- R3: While `capture_dr` is high, a rising edge loads `pad_in[p]` into pad p's input cell, `core_out[p]` into its output cell and `core_oe[p]` into its enable cell. The same edge loads 0 into the three non-pin cells.
- R4: While `shift_dr` is high and `capture_dr` is low, each rising edge moves every chain bit one place toward bit 0 and loads `tdi` into the last bit. `tdo` always shows bit 0.
- R5: The update latches change only on a rising edge with `update_dr` high. On that edge each latch loads its pad's shift cell.
- R6: While `extest` is high, `pad_out[p]` and `pad_oe[p]` follow pad p's output and enable update latches, and `core_in[p]` follows its input update latch.
- R7: While `extest` is low, `pad_out` equals `core_out`, `pad_oe` equals `core_oe` and `core_in` equals `pad_in`.
- R8: Synchronous active-low reset clears every shift cell and every update latch. After reset, external-test mode leaves all pads disabled, with `pad_oe` equal to 0.
- R9: If `capture_dr` and `shift_dr` are high on the same edge, capture takes priority. If `update_dr` and `shift_dr` are high on the same edge, the latches take the chain contents from before that shift.
- R10: While no strobe is high, the chain contents and `tdo` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_dr | input | 1 | Parallel-load strobe for the shift cells |
| shift_dr | input | 1 | Serial shift strobe |
| update_dr | input | 1 | Load strobe for the update latches |
| extest | input | 1 | External-test mode; pads are driven from the update latches |
| tdi | input | 1 | Serial data into the last chain bit |
| tdo | output | 1 | Serial data out of chain bit 0 |
| core_out | input | NUM_PADS | Output values from core logic |
| core_oe | input | NUM_PADS | Output enables from core logic, 1 = drive |
| pad_in | input | NUM_PADS | Values received at the pads |
| pad_out | output | NUM_PADS | Output value driven to each pad |
| pad_oe | output | NUM_PADS | Output enable to each pad, 1 = drive |
| core_in | output | NUM_PADS | Input value presented to core logic |

## Verification
Two pairs of strobes can land on the same edge: shift with update, and capture with shift. The bench first loads a known pattern. It then raises `shift_dr` and `update_dr` together and checks that the pads, in external-test mode, show the pattern from before the shift while `tdo` shows the shifted pattern. In a separate test it raises `capture_dr` and `shift_dr` together, then unloads the chain and compares every bit with the captured pad and core values.

// File: rtl/bsr_pkg.sv
// Package: shared types and chain position helpers for the boundary scan chain.
// Assumes chain bit 0 is nearest tdo and two non-pin cells precede the pads.
package bsr_pkg;

    // Number of non-pin cells at the serial-out end of the chain.
    localparam int LOW_FIXED = 2;

    // One pad's three cells, as shift contents or as latched values.
    typedef struct packed {
        logic oe_b;
        logic out_b;
        logic in_b;
    } pad_bits_t;

    // Chain index of pad p's input cell.
    function automatic int pos_in(input int p);
        return LOW_FIXED + 3 * p;
    endfunction

    // Chain index of pad p's output cell.
    function automatic int pos_out(input int p);
        return LOW_FIXED + 3 * p + 1;
    endfunction

    // Chain index of pad p's enable cell.
    function automatic int pos_oe(input int p);
        return LOW_FIXED + 3 * p + 2;
    endfunction

endpackage

// File: rtl/bsr_fixed_cell.sv
// Module: a single non-pin chain cell with no update latch.
// Captures a constant, shifts from its upstream neighbour and holds otherwise.
module bsr_fixed_cell #(
    parameter logic CAP_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic shift,
    input  logic ser_in,
    output logic ser_out
);

    logic bit_q;

    // Capture the constant, shift, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_q <= 1'b0;
        else if (capture) bit_q <= CAP_VAL;
        else if (shift)   bit_q <= ser_in;
    end

    assign ser_out = bit_q;

endmodule

// File: rtl/bsr_pad_mux.sv
// Module: selects between core control and update-latch control of one pad.
// Purely combinational. Assumes the latch values are stable while extest is high.
module bsr_pad_mux
    import bsr_pkg::*;
(
    input  logic      extest,
    input  logic      core_out,
    input  logic      core_oe,
    input  logic      pad_in,
    input  pad_bits_t upd,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      core_in
);

    // Route pad and core signals according to the test mode.
    always_comb begin
        if (extest) begin
            pad_out = upd.out_b;
            pad_oe  = upd.oe_b;
            core_in = upd.in_b;
        end else begin
            pad_out = core_out;
            pad_oe  = core_oe;
            core_in = pad_in;
        end
    end

endmodule

// File: rtl/bsr_pad_cell.sv
// Module: one pad's three shift cells, three update latches and mode mux.
// Serial order inside the pad runs enable -> output -> input toward tdo.
// Assumes the TAP controller never raises capture and shift together; if it does, capture wins.
module bsr_pad_cell
    import bsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      capture,
    input  logic      shift,
    input  logic      update,
    input  logic      extest,
    input  logic      ser_in,
    input  logic      core_out,
    input  logic      core_oe,
    input  logic      pad_in,
    output pad_bits_t sh,
    output pad_bits_t upd,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      core_in
);

    pad_bits_t sh_q;
    pad_bits_t upd_q;

    // Shift cells: capture pad and core values, or move one place toward tdo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (capture) begin
            sh_q.in_b  <= pad_in;
            sh_q.out_b <= core_out;
            sh_q.oe_b  <= core_oe;
        end else if (shift) begin
            sh_q.in_b  <= sh_q.out_b;
            sh_q.out_b <= sh_q.oe_b;
            sh_q.oe_b  <= ser_in;
        end
    end

    // Update latches: reset to disabled, load from the shift cells on update.
    always_ff @(posedge clk) begin
        if (!rst_n)      upd_q <= '0;
        else if (update) upd_q <= sh_q;
    end

    assign sh  = sh_q;
    assign upd = upd_q;

    bsr_pad_mux u_mux (
        .extest   (extest),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_in   (pad_in),
        .upd      (upd_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .core_in  (core_in)
    );

endmodule

// File: rtl/bsr_chain.sv
// Module: boundary scan data register for NUM_PADS bidirectional pads.
// Chain: bit 0 TDO-enable, bit 1 TDO-data, then three cells per pad,
// last bit update-control. Strobes come from an external TAP controller.
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int NUM_PADS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                extest,
    input  logic                tdi,
    output logic                tdo,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] core_in
);

    localparam int CHAIN_LEN = 3 * NUM_PADS + 3;
    localparam int TOP_BIT   = CHAIN_LEN - 1;

    // link[j] is chain bit j; link[CHAIN_LEN] is the serial input.
    logic [CHAIN_LEN:0]   link;
    logic [CHAIN_LEN-1:0] chain_q;
    logic [NUM_PADS-1:0]  upd_in;
    logic [NUM_PADS-1:0]  upd_out;
    logic [NUM_PADS-1:0]  upd_oe;

    assign link[CHAIN_LEN] = tdi;

    // Non-pin cells at the serial-out end (bits 0 and 1).
    generate
        for (genvar f = 0; f < LOW_FIXED; f++) begin : g_low
            bsr_fixed_cell #(.CAP_VAL(1'b0)) u_fix (
                .clk     (clk),
                .rst_n   (rst_n),
                .capture (capture_dr),
                .shift   (shift_dr),
                .ser_in  (link[f+1]),
                .ser_out (link[f])
            );
        end
    endgenerate

    // Update-control cell at the serial-in end.
    bsr_fixed_cell #(.CAP_VAL(1'b0)) u_top_fix (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture_dr),
        .shift   (shift_dr),
        .ser_in  (link[CHAIN_LEN]),
        .ser_out (link[TOP_BIT])
    );

    // One cell group per pad, chained toward bit 0.
    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
            pad_bits_t sh_p;
            pad_bits_t upd_p;

            bsr_pad_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .capture  (capture_dr),
                .shift    (shift_dr),
                .update   (update_dr),
                .extest   (extest),
                .ser_in   (link[pos_oe(p)+1]),
                .core_out (core_out[p]),
                .core_oe  (core_oe[p]),
                .pad_in   (pad_in[p]),
                .sh       (sh_p),
                .upd      (upd_p),
                .pad_out  (pad_out[p]),
                .pad_oe   (pad_oe[p]),
                .core_in  (core_in[p])
            );

            assign link[pos_in(p)]  = sh_p.in_b;
            assign link[pos_out(p)] = sh_p.out_b;
            assign link[pos_oe(p)]  = sh_p.oe_b;
            assign upd_in[p]        = upd_p.in_b;
            assign upd_out[p]       = upd_p.out_b;
            assign upd_oe[p]        = upd_p.oe_b;
        end
    endgenerate

    assign chain_q = link[CHAIN_LEN-1:0];
    assign tdo     = link[0];

endmodule

// File: rtl/bsr_chain_chk.sv
// Module: assertion checker for bsr_chain, attached with bind below.
// Observes ports and the chain and latch state that the top module exposes.
module bsr_chain_chk
    import bsr_pkg::*;
#(
    parameter int NUM_PADS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    capture_dr,
    input logic                    shift_dr,
    input logic                    update_dr,
    input logic                    extest,
    input logic                    tdo,
    input logic [NUM_PADS-1:0]     core_out,
    input logic [NUM_PADS-1:0]     core_oe,
    input logic [NUM_PADS-1:0]     pad_in,
    input logic [NUM_PADS-1:0]     pad_out,
    input logic [NUM_PADS-1:0]     pad_oe,
    input logic [NUM_PADS-1:0]     core_in,
    input logic [3*NUM_PADS+2:0]   chain_q,
    input logic [NUM_PADS-1:0]     upd_in,
    input logic [NUM_PADS-1:0]     upd_out,
    input logic [NUM_PADS-1:0]     upd_oe
);

    logic [NUM_PADS-1:0] view_in;
    logic [NUM_PADS-1:0] view_out;
    logic [NUM_PADS-1:0] view_oe;

    // Pull each pad's shift cells out of the flat chain.
    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_view
            assign view_in[p]  = chain_q[pos_in(p)];
            assign view_out[p] = chain_q[pos_out(p)];
            assign view_oe[p]  = chain_q[pos_oe(p)];
        end
    endgenerate

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr |=> (view_in == $past(pad_in)) && (view_out == $past(core_out)) && (view_oe == $past(core_oe))); // R3

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_dr && !capture_dr) |=> tdo == $past(chain_q[1])); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !update_dr |=> $stable(upd_in) && $stable(upd_out) && $stable(upd_oe)); // R5

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        update_dr |=> (upd_oe == $past(view_oe)) && (upd_out == $past(view_out)) && (upd_in == $past(view_in))); // R5

    AST_EXTEST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        extest |-> (pad_out == upd_out) && (pad_oe == upd_oe) && (core_in == upd_in)); // R6

    AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !extest |-> (pad_out == core_out) && (pad_oe == core_oe) && (core_in == pad_in)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_dr && !shift_dr) |=> $stable(chain_q)); // R10

endmodule

bind bsr_chain bsr_chain_chk #(.NUM_PADS(NUM_PADS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .extest     (extest),
    .tdo        (tdo),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .core_in    (core_in),
    .chain_q    (chain_q),
    .upd_in     (upd_in),
    .upd_out    (upd_out),
    .upd_oe     (upd_oe)
);

// File: tb/bsr_chain_bench.sv
// Bench: directed scenarios for bsr_chain, one task each, self-checking.
module bsr_chain_bench;

    localparam int NP  = 4;
    localparam int LEN = 3 * NP + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          capture_dr = 1'b0;
    logic          shift_dr = 1'b0;
    logic          update_dr = 1'b0;
    logic          extest = 1'b0;
    logic          tdi = 1'b0;
    logic          tdo;
    logic [NP-1:0] core_out = '0;
    logic [NP-1:0] core_oe = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] core_in;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    bsr_chain #(.NUM_PADS(NP)) u_bsr_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .extest     (extest),
        .tdi        (tdi),
        .tdo        (tdo),
        .core_out   (core_out),
        .core_oe    (core_oe),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .core_in    (core_in)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_shift(input logic b);
        @(negedge clk); shift_dr = 1'b1; tdi = b;
        @(negedge clk); shift_dr = 1'b0; tdi = 1'b0;
    endtask

    task automatic pulse_capture();
        @(negedge clk); capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk); update_dr = 1'b1;
        @(negedge clk); update_dr = 1'b0;
    endtask

    // Shift in a pattern so that chain bit j ends up holding pat[j].
    task automatic load_chain(input logic [LEN-1:0] pat);
        for (int i = 0; i < LEN; i++) do_shift(pat[i]);
    endtask

    // Unload the chain, comparing tdo with exp bit by bit.
    task automatic read_chain(input logic [LEN-1:0] exp, input string tag);
        for (int i = 0; i < LEN; i++) begin
            check(tdo === exp[i], tag, {31'b0, tdo}, {31'b0, exp[i]});
            do_shift(1'b0);
        end
    endtask

    function automatic logic [LEN-1:0] cap_image(input logic [NP-1:0] pi, input logic [NP-1:0] co, input logic [NP-1:0] ce);
        logic [LEN-1:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            v[2+3*p] = pi[p];
            v[3+3*p] = co[p];
            v[4+3*p] = ce[p];
        end
        return v;
    endfunction

    // R8: reset clears latches; extest then drives nothing.
    task automatic t_reset();
        extest = 1'b1; core_out = '1; core_oe = '1; pad_in = '1;
        @(negedge clk);
        check(pad_oe === '0, "R8 pad_oe after reset", 32'(pad_oe), 0);
        check(pad_out === '0, "R8 pad_out after reset", 32'(pad_out), 0);
        check(core_in === '0, "R8 core_in after reset", 32'(core_in), 0);
        check(tdo === 1'b0, "R8 tdo after reset", 32'(tdo), 0);
        extest = 1'b0;
    endtask

    // R7: normal mode passes core and pad values straight through.
    task automatic t_normal();
        logic [NP-1:0] pats [3] = '{4'hA, 4'h5, 4'h3};
        foreach (pats[k]) begin
            core_out = pats[k]; core_oe = ~pats[k]; pad_in = pats[k] ^ 4'h6;
            #1;
            check(pad_out === core_out, "R7 pad_out", 32'(pad_out), 32'(core_out));
            check(pad_oe === core_oe, "R7 pad_oe", 32'(pad_oe), 32'(core_oe));
            check(core_in === pad_in, "R7 core_in", 32'(core_in), 32'(pad_in));
        end
    endtask

    // R2 R3: capture then unload; every bit position is compared.
    task automatic t_capture();
        pad_in = 4'b1011; core_out = 4'b0110; core_oe = 4'b1100;
        pulse_capture();
        read_chain(cap_image(4'b1011, 4'b0110, 4'b1100), "R2 R3 capture order");
        pad_in = 4'b0100; core_out = 4'b1001; core_oe = 4'b0011;
        pulse_capture();
        read_chain(cap_image(4'b0100, 4'b1001, 4'b0011), "R3 capture second pattern");
    endtask

    // R1 R4 R10: shift a full-length pattern, idle, then recover it.
    task automatic t_shift();
        logic [LEN-1:0] pat = 15'h5A3C;
        load_chain(pat);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(tdo === pat[0], "R10 idle hold", 32'(tdo), 32'(pat[0]));
        end
        read_chain(pat, "R1 R4 shift length");
    endtask

    // R5 R6: pads change only at update and then follow the latches.
    task automatic t_update();
        logic [LEN-1:0] pat = cap_image(4'b1001, 4'b0101, 4'b0111);
        logic [LEN-1:0] pat2 = ~pat;
        extest = 1'b1;
        load_chain(pat);
        check(pad_oe === '0, "R5 no update yet", 32'(pad_oe), 0);
        pulse_update();
        check(pad_out === 4'b0101, "R6 pad_out from latch", 32'(pad_out), 32'h5);
        check(pad_oe === 4'b0111, "R6 pad_oe from latch", 32'(pad_oe), 32'h7);
        check(core_in === 4'b1001, "R6 core_in from latch", 32'(core_in), 32'h9);
        core_out = ~core_out; core_oe = ~core_oe; pad_in = ~pad_in;
        #1;
        check(pad_out === 4'b0101, "R6 core_out ignored", 32'(pad_out), 32'h5);
        load_chain(pat2);
        check(pad_oe === 4'b0111, "R5 shift leaves latches", 32'(pad_oe), 32'h7);
        pulse_capture();
        check(pad_out === 4'b0101, "R5 capture leaves latches", 32'(pad_out), 32'h5);
        extest = 1'b0;
    endtask

    // R9: shift+update and capture+shift on the same edge.
    task automatic t_collide();
        logic [LEN-1:0] pat = cap_image(4'b0110, 4'b1010, 4'b1101) | 15'h0002;
        extest = 1'b1;
        load_chain(pat);
        @(negedge clk); shift_dr = 1'b1; update_dr = 1'b1; tdi = 1'b1;
        @(negedge clk); shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
        check(pad_out === 4'b1010, "R9 update takes pre-shift out", 32'(pad_out), 32'hA);
        check(pad_oe === 4'b1101, "R9 update takes pre-shift oe", 32'(pad_oe), 32'hD);
        check(core_in === 4'b0110, "R9 update takes pre-shift in", 32'(core_in), 32'h6);
        check(tdo === pat[1], "R9 chain still shifted", 32'(tdo), 32'(pat[1]));
        extest = 1'b0;
        pad_in = 4'b1110; core_out = 4'b0001; core_oe = 4'b1010;
        @(negedge clk); capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
        @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
        read_chain(cap_image(4'b1110, 4'b0001, 4'b1010), "R9 capture beats shift");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_capture();
        t_shift();
        t_update();
        t_collide();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule